// File: doc/BRIEF.md
# Network Interface Packetizer for an On-Chip Packet Network

This block sits between one local processor and its port on an on-chip packet network. To send a packet, the processor writes a packet kind, a destination node number and a payload word into three staging registers on a small register port, then pulses a separate strobe pin. Only when all three fields have been written since the last launch does the strobe produce a packet. The packet goes toward the router under a valid/ready handshake and is held until the router accepts it.

In the other direction, the block accepts packets from the router. Data packets are queued in a four-entry FIFO, and the processor reads them back field by field. Reading the payload register removes the head entry. A status register reports whether the FIFO is empty, how many packets it holds, whether a transmit is pending and whether the processor is halted. Stop and resume control packets addressed to this node are handled inside the block and drive a halt output to the processor. They never enter the FIFO.

A packet is 22 bits wide. From the most significant bit down it holds the kind in [21:20], the destination in [19:16] and the payload in [15:0]. The kind codes are 00 for data, 01 for stop, 10 for resume and 11 for reserved. The register offsets are: 0 for the transmit kind (write), 1 for the transmit destination (write), 2 for the transmit payload (write), 4 for status (read), 5 for the receive head fields (read) and 6 for the receive payload (read, pops).

Top module: `noc_ni_top`

## Requirements
- R1: After reset, net_out_valid and cpu_halt are 0, net_in_ready is 1 and the status register reads 0.
- R2: A cpu_strobe pulse, given after offsets 0, 1 and 2 have all been written, raises net_out_valid at the next clock edge. net_out_pkt then carries {kind[1:0], dest[3:0], payload[15:0]}.
- R3: A strobe is ignored if any of the three transmit fields has not been written since the last launch. No packet is produced.
- R4: While net_out_valid is high and net_out_ready is low, the packet stays unchanged and status bit 0 (busy) reads 1. A strobe given in this state launches nothing.
- R5: net_out_valid drops at the edge where net_out_ready is high. After that, all three fields must be written again before a strobe launches another packet.
- R6: Data packets (kind 00) are read out in arrival order. Offset 5 returns {dest, kind} in bits [5:0]. Offset 6 returns the payload and removes the entry.
- R7: Status bit 1 reads 1 when the FIFO holds a packet. Status bits [4:2] give the number of stored packets, which changes at the edge after a push or pop.
- R8: With four data packets stored, net_in_ready is 0 whenever a data packet is offered. Control packets are still accepted.
- R9: If a payload read (offset 6) happens in the same cycle that a data packet is being written into the FIFO, bus_wait is 1, no entry is removed, and the read must be retried.
- R10: An accepted stop packet (kind 01) whose destination equals NODE_ID sets cpu_halt at the next edge. It is not stored, so the count does not change.
- R11: A resume packet (kind 10) addressed to NODE_ID clears cpu_halt. A stop packet for another node leaves cpu_halt unchanged.
- R12: A reserved packet (kind 11) is accepted and discarded. The count and cpu_halt do not change.
- R13: Status bit 5 mirrors cpu_halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| cpu_strobe | input | 1 | Fields-valid strobe that launches a packet |
| bus_rdata | output | 16 | Read data (combinational) |
| bus_wait | output | 1 | Payload read deferred because of a concurrent FIFO write |
| net_out_valid | output | 1 | Outgoing packet valid |
| net_out_ready | input | 1 | Router accepts the outgoing packet |
| net_out_pkt | output | 22 | Outgoing packet |
| net_in_valid | input | 1 | Incoming packet valid |
| net_in_ready | output | 1 | Block accepts the incoming packet |
| net_in_pkt | input | 22 | Incoming packet |
| cpu_halt | output | 1 | Halt request to the local processor |

## Verification
The assertions assume the processor never writes a field in the same cycle as it strobes. They also assume the processor issues a payload read only when the status register shows a stored packet. Finally, they assume the router keeps an incoming packet steady while net_in_ready is low. The stimulus writes each field in its own cycle and strobes one cycle later. It reads the payload only after reading the status register or computing the count from the packets it sent. It holds net_in_valid and net_in_pkt until the cycle in which the block is ready.

// File: rtl/noc_ni_pkg.sv
// Shared packet layout and register offsets for the network interface.
// Assumes the router and this block agree on the field order kind/dest/payload.
package noc_ni_pkg;
    parameter int KIND_W = 2;
    parameter int DEST_W = 4;
    parameter int WORD_W = 16;
    localparam int PKT_W = KIND_W + DEST_W + WORD_W;

    typedef enum logic [KIND_W-1:0] {
        K_DATA   = 2'b00,
        K_STOP   = 2'b01,
        K_RESUME = 2'b10,
        K_RSVD   = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [DEST_W-1:0] dest;
        logic [WORD_W-1:0] data;
    } pkt_t;

    localparam int ADDR_W      = 3;
    localparam int OFF_TX_KIND = 0;
    localparam int OFF_TX_DEST = 1;
    localparam int OFF_TX_DATA = 2;
    localparam int OFF_STATUS  = 4;
    localparam int OFF_RX_HEAD = 5;
    localparam int OFF_RX_DATA = 6;
endpackage

// File: rtl/ni_tx_builder.sv
// Transmit staging registers and outgoing handshake.
// Assumes a field write and a strobe never fall in the same cycle. A strobe
// only checks the fields written in earlier cycles.
module ni_tx_builder
    import noc_ni_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              strobe,
    input  logic              out_ready,
    output logic              out_valid,
    output pkt_t              out_pkt,
    output logic              busy
);
    kind_e             kind_q;
    logic [DEST_W-1:0] dest_q;
    logic [WORD_W-1:0] data_q;
    logic              have_kind, have_dest, have_data;
    logic              launch;

    // Launch when every field is present and the previous packet is gone.
    assign launch = strobe && have_kind && have_dest && have_data && !out_valid;
    assign busy   = out_valid;

    // Staging registers, field-present flags and the outgoing packet register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_DATA;
            dest_q    <= '0;
            data_q    <= '0;
            have_kind <= 1'b0;
            have_dest <= 1'b0;
            have_data <= 1'b0;
            out_valid <= 1'b0;
            out_pkt   <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (wr_en) begin
                case (int'(wr_addr))
                    OFF_TX_KIND: begin kind_q <= kind_e'(wr_data[KIND_W-1:0]); have_kind <= 1'b1; end
                    OFF_TX_DEST: begin dest_q <= wr_data[DEST_W-1:0];          have_dest <= 1'b1; end
                    OFF_TX_DATA: begin data_q <= wr_data;                      have_data <= 1'b1; end
                    default: ;
                endcase
            end
            if (launch) begin
                out_pkt   <= '{kind: kind_q, dest: dest_q, data: data_q};
                out_valid <= 1'b1;
                have_kind <= 1'b0;
                have_dest <= 1'b0;
                have_data <= 1'b0;
            end
        end
    end

    // R4: an unaccepted packet holds still.
    a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pkt));
    // R3: a new packet only ever follows a strobe.
    a_r3_launch_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(strobe));
    // R5: acceptance retires the packet.
    a_r5_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);
endmodule

// File: rtl/ni_rx_fifo.sv
// Receive queue of data packets with an occupancy count.
// Assumes DEPTH is a power of two, and that the caller never pushes when full
// or pops when empty.
module ni_rx_fifo
    import noc_ni_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  pkt_t             push_pkt,
    input  logic             pop,
    output pkt_t             head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    pkt_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_pkt;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_W'(DEPTH));
endmodule

// File: rtl/ni_rx_sorter.sv
// Sorts incoming packets. Data goes to the FIFO; stop and resume drive the
// halt flag; reserved packets are dropped. Assumes the router keeps a
// packet steady while ready is low.
module ni_rx_sorter
    import noc_ni_pkg::*;
#(
    parameter logic [DEST_W-1:0] NODE_ID = 4'd3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  pkt_t in_pkt,
    input  logic fifo_full,
    output logic in_ready,
    output logic push,
    output logic halt
);
    logic is_data, for_me;

    assign is_data  = (in_pkt.kind == K_DATA);
    assign for_me   = (in_pkt.dest == NODE_ID);
    assign in_ready = !is_data || !fifo_full;
    assign push     = in_valid && is_data && !fifo_full;

    // Halt flag: set by a stop for this node, cleared by a resume for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt <= 1'b0;
        end else if (in_valid && for_me) begin
            if (in_pkt.kind == K_STOP)        halt <= 1'b1;
            else if (in_pkt.kind == K_RESUME) halt <= 1'b0;
        end
    end

    a_r10_stop_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && for_me && in_pkt.kind == K_STOP |=> halt);
    a_r11_halt_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(in_valid && for_me && in_pkt.kind == K_STOP));
    a_r10_control_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> in_pkt.kind == K_DATA);
endmodule

// File: rtl/noc_ni_top.sv
// Network interface top: register port decode, transmit builder, receive
// sorter and FIFO. Assumes that payload reads are issued only when the
// status register shows a stored packet.
module noc_ni_top
    import noc_ni_pkg::*;
#(
    parameter int                NI_DEPTH = 4,
    parameter logic [DEST_W-1:0] NODE_ID  = 4'd3,
    localparam int CNT_W = $clog2(NI_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              cpu_strobe,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic              net_out_valid,
    input  logic              net_out_ready,
    output logic [PKT_W-1:0]  net_out_pkt,
    input  logic              net_in_valid,
    output logic              net_in_ready,
    input  logic [PKT_W-1:0]  net_in_pkt,
    output logic              cpu_halt
);
    pkt_t             tx_pkt, rx_head;
    logic             tx_busy, rx_push, rx_pop, pop_req, rx_full, rx_empty;
    logic [CNT_W-1:0] rx_count;

    ni_tx_builder u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_sel && bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .strobe(cpu_strobe), .out_ready(net_out_ready),
        .out_valid(net_out_valid), .out_pkt(tx_pkt), .busy(tx_busy)
    );
    assign net_out_pkt = tx_pkt;

    ni_rx_sorter #(.NODE_ID(NODE_ID)) u_sort (
        .clk(clk), .rst_n(rst_n),
        .in_valid(net_in_valid), .in_pkt(pkt_t'(net_in_pkt)), .fifo_full(rx_full),
        .in_ready(net_in_ready), .push(rx_push), .halt(cpu_halt)
    );

    ni_rx_fifo #(.DEPTH(NI_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_pkt(pkt_t'(net_in_pkt)), .pop(rx_pop),
        .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    // Collision guard: a payload read during a FIFO write is deferred.
    assign pop_req  = bus_sel && !bus_wr && int'(bus_addr) == OFF_RX_DATA && !rx_empty;
    assign bus_wait = pop_req && rx_push;
    assign rx_pop   = pop_req && !rx_push;

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFF_STATUS:  bus_rdata = WORD_W'({cpu_halt, rx_count, !rx_empty, tx_busy});
            OFF_RX_HEAD: bus_rdata = rx_empty ? '0 : WORD_W'({rx_head.dest, rx_head.kind});
            OFF_RX_DATA: bus_rdata = rx_empty ? '0 : rx_head.data;
            default:     bus_rdata = '0;
        endcase
    end

    // R9: a deferred read leaves the entry in place while the write lands.
    a_r9_wait_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> rx_count == $past(rx_count) + 1'b1);
    // R6: a granted payload read removes exactly one entry.
    a_r6_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> rx_count == $past(rx_count) - 1'b1);
endmodule

// File: tb/noc_ni_top_bench.sv
module noc_ni_top_bench;
    localparam logic [3:0] ME = 4'd3;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0, cpu_strobe = 0;
    logic [2:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        bus_wait, net_out_valid, net_out_ready = 0;
    logic [21:0] net_out_pkt, net_in_pkt = 0;
    logic        net_in_valid = 0, net_in_ready, cpu_halt;
    int total = 0, bad = 0;
    logic [15:0] rd;

    noc_ni_top #(.NODE_ID(ME)) u_noc_ni_top (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input logic h, input int c, input logic b);
        return {26'd0, h, c[2:0], (c != 0), b};
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rdreg(input int a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = 3'(a); #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic strobe();
        cpu_strobe = 1; @(negedge clk); cpu_strobe = 0;
    endtask

    task automatic send(input logic [21:0] p, output logic rdy);
        net_in_valid = 1; net_in_pkt = p; #1 rdy = net_in_ready;
        @(negedge clk); net_in_valid = 0;
    endtask

    task automatic accept();
        net_out_ready = 1; @(negedge clk); net_out_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", net_out_valid, 0);
        chk("R1 halt", cpu_halt, 0);
        chk("R1 in_ready", net_in_ready, 1);
        rdreg(4, rd); chk("R1 status", rd, 0);

        // R2 sweep of every kind and destination
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 16; d++) begin
                logic [15:0] pay = 16'(k * 4099 + d * 37 + 1);
                wr(0, 16'(k)); wr(1, 16'(d)); wr(2, pay);
                strobe();
                chk("R2 valid", net_out_valid, 1);
                chk("R2 pkt", net_out_pkt, {k[1:0], d[3:0], pay});
                if (d == 0) begin
                    // R4 hold, busy bit, strobe while busy ignored
                    wr(2, 16'hBEEF); wr(0, 0); wr(1, 16'(d));
                    strobe();
                    chk("R4 held", net_out_pkt, {k[1:0], d[3:0], pay});
                    rdreg(4, rd); chk("R4 busy", rd, st(0, 0, 1));
                    accept();
                    chk("R5 dropped", net_out_valid, 0);
                    strobe();
                    chk("R4 staged kept", net_out_pkt, {2'b00, d[3:0], 16'hBEEF});
                end
                accept();
                chk("R5 accept", net_out_valid, 0);
            end
        end
        // R5 no relaunch without rewriting
        strobe(); @(negedge clk);
        chk("R5 no relaunch", net_out_valid, 0);
        // R3 partial fields ignored
        wr(0, 0); wr(1, 5); strobe(); @(negedge clk);
        chk("R3 partial", net_out_valid, 0);
        wr(2, 16'h1234); strobe();
        chk("R3 complete", net_out_pkt, {2'b00, 4'd5, 16'h1234});
        accept();

        // R6/R7 fill-and-drain rounds of 1..4 packets
        for (int n = 1; n <= 4; n++) begin
            for (int i = 0; i < n; i++) begin
                send({2'b00, 4'(i + n), 16'(n * 256 + i)}, r);
                chk("R8 ready", r, 1);
            end
            rdreg(4, rd); chk("R7 count", rd, st(0, n, 0));
            if (n == 4) begin
                // R8 full back-pressure
                net_in_valid = 1; net_in_pkt = {2'b00, 4'd1, 16'h7777}; #1
                chk("R8 full", net_in_ready, 0);
                @(negedge clk); net_in_valid = 0;
                rdreg(4, rd); chk("R8 count", rd, st(0, 4, 0));
                // R10 stop accepted while full, not stored
                send({2'b01, ME, 16'h0}, r);
                chk("R10 ready", r, 1);
                chk("R10 halt", cpu_halt, 1);
                rdreg(4, rd); chk("R13 status", rd, st(1, 4, 0));
                // R11 resume clears
                send({2'b10, ME, 16'h0}, r);
                chk("R11 resume", cpu_halt, 0);
            end
            for (int i = 0; i < n; i++) begin
                rdreg(5, rd); chk("R6 head", rd, {10'd0, 4'(i + n), 2'b00});
                rdreg(6, rd); chk("R6 data", rd, 16'(n * 256 + i));
            end
            rdreg(4, rd); chk("R7 empty", rd, 0);
        end

        // R11 stop for another node
        send({2'b01, 4'd5, 16'h0}, r);
        chk("R11 other node", cpu_halt, 0);
        // R12 reserved kind dropped
        send({2'b11, ME, 16'h5555}, r);
        chk("R12 ready", r, 1);
        rdreg(4, rd); chk("R12 status", rd, 0);

        // R9 collision guard
        send({2'b00, 4'd2, 16'hAAAA}, r);
        net_in_valid = 1; net_in_pkt = {2'b00, 4'd4, 16'hBBBB};
        bus_sel = 1; bus_wr = 0; bus_addr = 3'd6; #1
        chk("R9 wait", bus_wait, 1);
        chk("R9 rdata", bus_rdata, 16'hAAAA);
        @(negedge clk); net_in_valid = 0; bus_sel = 0;
        rdreg(4, rd); chk("R9 count", rd, st(0, 2, 0));
        rdreg(6, rd); chk("R9 first", rd, 16'hAAAA);
        chk("R9 no wait", bus_wait, 0);
        rdreg(6, rd); chk("R9 second", rd, 16'hBBBB);
        rdreg(4, rd); chk("R9 drained", rd, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule